// File: doc/BRIEF.md
# Rotating Priority Interrupt Arbitration Core

This core arbitrates among eight interrupt request lines. Each line feeds a pending register, either as a held level or as a captured rising edge, chosen per line by a trigger-mode input. A mask input removes lines from contention. The remaining pending lines are ranked from a rotatable priority base, and the winner is compared against the highest-ranked line already being serviced. The interrupt output rises only when the winner strictly outranks that line.

A host pulses the acknowledge strobe while the interrupt output is high. The core then records the winning line as in service, or it leaves the in-service register alone in auto end-of-interrupt mode, where it can optionally rotate the priority base to the line after the winner. It also clears the winner's pending bit if that line is edge-triggered. Two exclusions adjust the in-service comparison: special mask mode drops masked in-service lines, and nested mode on a master drops in-service line 2, which carries a cascaded controller. The register interface and command decoding sit outside this core and drive its mode and mask inputs directly.

Top module: `irq_arb_core`

## Requirements
- R1: While `rstN` is low and after it is released, the pending, in-service and previous-level registers are zero and the priority base is 0, so `intOut` is 0 and `winIdx` is 0 until a request arrives.
- R2: An edge-triggered line (`trigLevel[i]`=0) sets its pending bit on the clock edge after its input goes from 0 to 1. An input that stays high sets nothing further, and a falling input leaves the pending bit set.
- R3: A level-triggered line (`trigLevel[i]`=1) has its pending bit equal to the input value sampled at the previous clock edge.
- R4: The candidate set is pending AND NOT `maskIn`. A change of `maskIn` affects `intOut` and `winIdx` in the same cycle, with no clock edge.
- R5: Rank k belongs to line (k + base) mod 8, rank 0 being highest. `winIdx` is the line with the lowest rank in the candidate set.
- R6: `intOut` is 1 only when the candidate's rank is strictly lower than the rank of the highest in-service line. A pending line ranked equal to or below that line raises nothing.
- R7: An acknowledge taken with `autoEoi`=0 sets the in-service bit of `winIdx`. Any taken acknowledge clears the winner's pending bit when the line is edge-triggered and leaves it unchanged when the line is level-triggered.
- R8: An acknowledge taken with `autoEoi`=1 leaves the in-service register unchanged. If `rotateAutoEoi`=1 as well, the priority base becomes (winner + 1) mod 8.
- R9: With `specialMask`=1, in-service lines whose mask bit is 1 are left out when the current in-service rank is computed.
- R10: With `nestedMode`=1 and `isMaster`=1, in-service line 2 is left out of the in-service rank. With `isMaster`=0 it counts as normal.
- R11: An acknowledge pulse while `intOut` is 0 changes neither the in-service register nor the priority base.
- R12: `winIdx` is 0 whenever `intOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 8 | Request lines, synchronous to clk |
| trigLevel | input | 8 | Per-line trigger mode: 1 level, 0 rising edge |
| maskIn | input | 8 | Per-line mask: 1 blocks the line |
| autoEoi | input | 1 | Auto end-of-interrupt mode |
| rotateAutoEoi | input | 1 | Rotate priority base on auto end-of-interrupt |
| specialMask | input | 1 | Leave masked lines out of the in-service rank |
| nestedMode | input | 1 | Nested mode that ignores the cascade line |
| isMaster | input | 1 | This core is the master in a cascade |
| ack | input | 1 | Acknowledge strobe, one cycle |
| intOut | output | 1 | Interrupt request to the host |
| winIdx | output | 3 | Index of the winning line, 0 when idle |

## Verification
The in-service register and the priority base cannot be read at the ports. They are also hard to set up, because the in-service register only fills through acknowledges and nothing in this core clears it. Each scenario therefore starts from reset and builds the state it needs through real acknowledges: a line is pulsed, then acknowledged, then a second line is pulsed. The hidden state is then judged through `intOut` and `winIdx`. A rotated base, for example, shows up as a line other than the lowest index winning, and an in-service bit that was wrongly set shows up as a lower-priority request being held off.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LINES  = 8;
  localparam int IDX_W  = $clog2(LINES);
  localparam int RANK_W = $clog2(LINES + 1);

  typedef struct packed {
    logic             take;      // acknowledge accepted
    logic             setIsr;    // mark winner in service
    logic             loadBase;  // rotate priority base past winner
    logic [IDX_W-1:0] idx;       // winning line
  } ctrlStrobe_t;

  // Rank of the highest-priority set bit, counting from base; LINES when empty.
  function automatic logic [RANK_W-1:0] findRank(input logic [LINES-1:0] m,
                                                 input logic [IDX_W-1:0] base);
    logic [RANK_W-1:0] r;
    r = RANK_W'(LINES);
    for (int k = LINES - 1; k >= 0; k--) begin
      if (m[(k + int'(base)) % LINES]) r = RANK_W'(k);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_arb_control.sv
module irq_arb_control
  import irq_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ack,
  input  logic             intOut,
  input  logic [IDX_W-1:0] winIdx,
  input  logic             autoEoi,
  input  logic             rotateAutoEoi,
  output ctrlStrobe_t      strobe
);
  always_comb begin
    strobe.take     = ack & intOut;
    strobe.setIsr   = ack & intOut & ~autoEoi;
    strobe.loadBase = ack & intOut & autoEoi & rotateAutoEoi;
    strobe.idx      = winIdx;
  end

  AST_AEOI_NO_MARK: assert property (@(posedge clk) disable iff (!rstN)
    (ack && autoEoi) |-> !strobe.setIsr); // R8
endmodule

// File: rtl/irq_arb_datapath.sv
module irq_arb_datapath
  import irq_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] reqIn,
  input  logic [LINES-1:0] trigLevel,
  input  logic [LINES-1:0] maskIn,
  input  logic             specialMask,
  input  logic             nestedMode,
  input  logic             isMaster,
  input  ctrlStrobe_t      strobe,
  output logic             intOut,
  output logic [IDX_W-1:0] winIdx
);
  localparam int CASCADE_LINE = 2;

  logic [LINES-1:0]  pend, prevLvl, isr;
  logic [IDX_W-1:0]  base;
  logic [LINES-1:0]  edgeSet, clrMask, pendNext, cand, isrView, winHot;
  logic [RANK_W-1:0] candRank, curRank;
  logic              pastValid;

  // Arbitration, purely from registered state and live mode inputs.
  always_comb begin
    cand    = pend & ~maskIn;
    isrView = isr;
    if (specialMask) isrView = isrView & ~maskIn;
    if (nestedMode && isMaster) isrView[CASCADE_LINE] = 1'b0;
    candRank = findRank(cand, base);
    curRank  = findRank(isrView, base);
    intOut   = (candRank < curRank);
    winIdx   = intOut ? IDX_W'((int'(candRank) + int'(base)) % LINES) : '0;
  end

  // Pending capture and acknowledge clearing.
  always_comb begin
    winHot  = '0;
    winHot[strobe.idx] = 1'b1;
    edgeSet = reqIn & ~prevLvl & ~trigLevel;
    clrMask = strobe.take ? (winHot & ~trigLevel) : '0;
    pendNext = (((pend & ~clrMask) | edgeSet) & ~trigLevel) | (reqIn & trigLevel);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend      <= '0;
      prevLvl   <= '0;
      isr       <= '0;
      base      <= '0;
      pastValid <= 1'b0;
    end else begin
      pend      <= pendNext;
      prevLvl   <= reqIn;
      pastValid <= 1'b1;
      if (strobe.setIsr) isr[strobe.idx] <= 1'b1;
      if (strobe.loadBase) base <= IDX_W'((int'(strobe.idx) + 1) % LINES);
    end
  end

  AST_INT_HAS_CAND: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> (pend[winIdx] && !maskIn[winIdx])); // R4
  AST_IDLE_IDX_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !intOut |-> (winIdx == '0)); // R12
  AST_MARK_WINNER: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setIsr |=> isr[$past(strobe.idx)]); // R7
  AST_AEOI_ISR_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && !strobe.setIsr) |=> $stable(isr)); // R8
  AST_BASE_ROTATE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadBase |=> (base == IDX_W'((int'($past(strobe.idx)) + 1) % LINES))); // R8
  AST_SPURIOUS_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !intOut |=> ($stable(isr) && $stable(base))); // R11

  for (genvar i = 0; i < LINES; i++) begin : g_lineChk
    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rstN)
      (pastValid && $past(trigLevel[i])) |-> (pend[i] == $past(reqIn[i]))); // R3
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (pastValid && !$past(trigLevel[i]) && $past(pend[i]) &&
       !($past(strobe.take) && $past(strobe.idx) == IDX_W'(i))) |-> pend[i]); // R2
  end
endmodule

// File: rtl/irq_arb_core.sv
module irq_arb_core
  import irq_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] reqIn,
  input  logic [LINES-1:0] trigLevel,
  input  logic [LINES-1:0] maskIn,
  input  logic             autoEoi,
  input  logic             rotateAutoEoi,
  input  logic             specialMask,
  input  logic             nestedMode,
  input  logic             isMaster,
  input  logic             ack,
  output logic             intOut,
  output logic [IDX_W-1:0] winIdx
);
  ctrlStrobe_t strobe;

  irq_arb_control i_ctrl (
    .clk(clk), .rstN(rstN), .ack(ack), .intOut(intOut), .winIdx(winIdx),
    .autoEoi(autoEoi), .rotateAutoEoi(rotateAutoEoi), .strobe(strobe)
  );

  irq_arb_datapath i_dp (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .trigLevel(trigLevel),
    .maskIn(maskIn), .specialMask(specialMask), .nestedMode(nestedMode),
    .isMaster(isMaster), .strobe(strobe), .intOut(intOut), .winIdx(winIdx)
  );
endmodule

// File: tb/test_irq_arb_core.sv
module test_irq_arb_core;
  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] reqIn, trigLevel, maskIn;
  logic       autoEoi, rotateAutoEoi, specialMask, nestedMode, isMaster, ack;
  logic       intOut;
  logic [2:0] winIdx;
  int         nChecks = 0;
  int         nFails = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  irq_arb_core i_irq_arb_core (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .trigLevel(trigLevel),
    .maskIn(maskIn), .autoEoi(autoEoi), .rotateAutoEoi(rotateAutoEoi),
    .specialMask(specialMask), .nestedMode(nestedMode), .isMaster(isMaster),
    .ack(ack), .intOut(intOut), .winIdx(winIdx)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkOut(string req, logic expInt, logic [2:0] expIdx);
    check({req, " intOut"}, {7'd0, intOut}, {7'd0, expInt});
    check({req, " winIdx"}, {5'd0, winIdx}, {5'd0, expIdx});
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic pulseAck();
    ack = 1'b1; cyc(); ack = 1'b0;
  endtask

  task automatic pulseReq(logic [7:0] v);
    reqIn = v; cyc(); reqIn = 8'h00; cyc();
  endtask

  task automatic doReset();
    rstN = 1'b0; reqIn = '0; trigLevel = '0; maskIn = '0; ack = 1'b0;
    autoEoi = 1'b0; rotateAutoEoi = 1'b0; specialMask = 1'b0;
    nestedMode = 1'b0; isMaster = 1'b0;
    cyc(); cyc();
    rstN = 1'b1;
    cyc();
  endtask

  task automatic testReset();
    doReset();
    checkOut("R1 reset", 1'b0, 3'd0);
  endtask

  task automatic testEdge();
    doReset();
    pulseReq(8'h02);
    checkOut("R2 pending kept after fall", 1'b1, 3'd1);
    doReset();
    reqIn = 8'h20; cyc();
    checkOut("R5 single edge", 1'b1, 3'd5);
    pulseAck();
    checkOut("R7 edge pending cleared, isr set", 1'b0, 3'd0);
    cyc();
    checkOut("R2 held high no re-capture", 1'b0, 3'd0);
    reqIn = 8'h00; cyc();
    reqIn = 8'h20; cyc();
    checkOut("R6 equal rank blocked", 1'b0, 3'd0);
    reqIn = 8'h28; cyc();
    checkOut("R6 higher rank passes", 1'b1, 3'd3);
  endtask

  task automatic testLevel();
    doReset();
    trigLevel = 8'h01; autoEoi = 1'b1;
    reqIn = 8'h01; cyc();
    checkOut("R3 level captured", 1'b1, 3'd0);
    pulseAck();
    checkOut("R8 R7 level kept, isr untouched", 1'b1, 3'd0);
    reqIn = 8'h00; cyc();
    checkOut("R3 level follows low", 1'b0, 3'd0);
  endtask

  task automatic testMask();
    doReset();
    pulseReq(8'h81);
    checkOut("R5 lowest index wins", 1'b1, 3'd0);
    maskIn = 8'h01; #1;
    checkOut("R4 mask same cycle", 1'b1, 3'd7);
    maskIn = 8'hFF; #1;
    checkOut("R12 all masked", 1'b0, 3'd0);
    maskIn = 8'h00; #1;
    checkOut("R4 unmask", 1'b1, 3'd0);
  endtask

  task automatic testRotate();
    doReset();
    autoEoi = 1'b1; rotateAutoEoi = 1'b1;
    pulseReq(8'h04);
    checkOut("R5 line2", 1'b1, 3'd2);
    pulseAck();
    checkOut("R8 edge cleared", 1'b0, 3'd0);
    pulseReq(8'h11);
    checkOut("R8 rotated base favours line4", 1'b1, 3'd4);
  endtask

  task automatic testSpurious();
    doReset();
    pulseAck();
    cyc();
    pulseReq(8'h80);
    checkOut("R11 spurious ack ignored", 1'b1, 3'd7);
  endtask

  task automatic testSpecialMask();
    doReset();
    pulseReq(8'h02);
    pulseAck();
    pulseReq(8'h10);
    checkOut("R6 lower behind isr", 1'b0, 3'd0);
    maskIn = 8'h02; specialMask = 1'b1; #1;
    checkOut("R9 masked isr excluded", 1'b1, 3'd4);
    specialMask = 1'b0; #1;
    checkOut("R9 off restores block", 1'b0, 3'd0);
  endtask

  task automatic testNested();
    doReset();
    nestedMode = 1'b1; isMaster = 1'b1;
    pulseReq(8'h04);
    pulseAck();
    pulseReq(8'h04);
    checkOut("R10 cascade isr ignored", 1'b1, 3'd2);
    pulseReq(8'h08);
    checkOut("R10 line2 still first", 1'b1, 3'd2);
    isMaster = 1'b0; #1;
    checkOut("R10 not master blocks", 1'b0, 3'd0);
  endtask

  initial begin
    testReset();
    testEdge();
    testLevel();
    testMask();
    testRotate();
    testSpurious();
    testSpecialMask();
    testNested();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule